// File: doc/BRIEF.md
# Single-Clock FIFO with Newest-Entry Replace

This block is a synchronous first-in first-out queue. It stores up to `DEPTH` words of `WIDTH` bits and reports its occupancy count, a flag that says a word can be taken and a flag that says a word can be accepted. `DEPTH` may be any value of two or more. The read and write pointers step back to slot 0 by comparing against the last slot, so non-power-of-two depths waste no storage.

A build-time parameter picks the read style. In fall-through mode the oldest stored word is always on the output, and a read request only advances past it. In registered mode the output is a flop: it loads the oldest word on the clock edge that accepts a read and keeps its value otherwise.

A replace input turns a write into an overwrite of the most recently stored word. The occupancy count does not change. This is useful when a producer wants to refine the last item it queued before the consumer reaches it. A replace is allowed when the queue is full and has no effect when the queue is empty.

Top module: `sfifo_replace`

## Requirements
- R1: While the active-low reset is held and on the first cycle after it is released, the level is 0, the readable flag is low and the writable flag is high. In registered mode the output is 0.
- R2: On each clock edge the level goes up by 1 when write enable and writable are high and replace is low. It goes down by 1 when read enable and readable are high. Both changes may happen in the same cycle.
- R3: Readable is high exactly when the level is nonzero, and writable is high exactly when the level is below `DEPTH`.
- R4: In fall-through mode with a nonzero level, the output equals the oldest stored word. It does not change across a cycle without a read request, except when the level is 1 after an accepted write, in which case it equals the word written in the previous cycle.
- R5: In registered mode the output changes only on the edge that accepts a read (read enable with readable high). It then shows the word that was oldest before that edge.
- R6: A write with replace high and a nonzero level overwrites the newest stored word, also when the queue is full. It leaves the level and the order of the other words unchanged.
- R7: A write with replace high while the queue is empty stores nothing and leaves the level at 0.
- R8: A write while writable is low is dropped, and a read while readable is low changes neither the level nor the stored words.
- R9: Words leave in the order they were accepted across any number of pointer wrap-arounds, including at a depth that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| rep_i | input | 1 | With a write request, overwrite the newest word instead of appending |
| wr_data_i | input | WIDTH | Word to write |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | WIDTH | Oldest word (fall-through) or last word read (registered) |
| readable_o | output | 1 | At least one word is stored |
| writable_o | output | 1 | At least one slot is free |
| level_o | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench builds two instances from the same stimulus. One is in fall-through mode with a depth of 5, and the other is in registered mode with a depth of 4. The depth of 5 makes the wrap-around compare fire at a slot that binary overflow would never reach. The depth of 4 fills earlier, so the same stimulus drives the two queues into different full, dropped-write and replace-at-full situations. A long pseudo-random phase wraps both pointers many times, and a reset in mid-run shows that the state clears from a non-empty queue.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Next slot index, wrapping by compare so any depth works.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Previous slot index, i.e. where the newest word sits relative to the write pointer.
  function automatic int unsigned wrap_dec(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // Occupancy after one edge.
  function automatic int unsigned level_step(input int unsigned lvl, input logic push,
                                             input logic pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] prev_o
);
  import sfifo_pkg::*;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= AW'(wrap_inc(32'(ptr_q), DEPTH));
  end

  assign ptr_o  = ptr_q;
  assign prev_o = AW'(wrap_dec(32'(ptr_q), DEPTH));

  // R9: the pointer never leaves the slot range
  p_ptr_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < DEPTH);
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 5,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [LW-1:0] level_o,
  output logic          readable_o,
  output logic          writable_o
);
  import sfifo_pkg::*;

  logic [LW-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= LW'(level_step(32'(level_q), push_i, pop_i));
  end

  assign level_o    = level_q;
  assign readable_o = (level_q != '0);
  assign writable_o = (32'(level_q) != DEPTH);

  // R1: state right after reset release
  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (level_q == '0));
  // R3 / R8: occupancy never leaves 0..DEPTH
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_q) <= DEPTH);
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '0) |=> !(pop_i && !push_i && level_q == '1));
endmodule

// File: rtl/sfifo_replace.sv
module sfifo_replace #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 5,
  parameter bit          FWFT  = 1'b1,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rep_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             readable_o,
  output logic             writable_o,
  output logic [LW-1:0]    level_o
);
  // Named internal events
  logic             ev_push;     // append a new word
  logic             ev_over;     // overwrite newest word
  logic             ev_wr_acc;   // any accepted write
  logic             ev_pop;      // accepted read
  logic             readable, writable;
  logic [AW-1:0]    wr_ptr, wr_prev, rd_ptr, rd_prev_unused;
  logic [WIDTH-1:0] head;
  logic [LW-1:0]    level;

  assign ev_push   = wr_en_i && !rep_i && writable;
  assign ev_over   = wr_en_i &&  rep_i && readable;
  assign ev_wr_acc = ev_push || ev_over;
  assign ev_pop    = rd_en_i && readable;

  sfifo_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(ev_push),
    .ptr_o(wr_ptr), .prev_o(wr_prev)
  );

  sfifo_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(ev_pop),
    .ptr_o(rd_ptr), .prev_o(rd_prev_unused)
  );

  sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .we_i(ev_wr_acc),
    .waddr_i(ev_over ? wr_prev : wr_ptr), .wdata_i(wr_data_i),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  sfifo_level #(.DEPTH(DEPTH)) u_level (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(ev_push), .pop_i(ev_pop),
    .level_o(level), .readable_o(readable), .writable_o(writable)
  );

  // One cycle after reset release, so $past never looks into reset
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  generate
    if (FWFT) begin : g_fwft
      assign rd_data_o = head;

      // R4: output holds without a read, except level 1 after an accepted write
      p_hold_fwft_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && !$past(rd_en_i) && !(level == LW'(1) && $past(ev_wr_acc)))
          |-> $stable(rd_data_o));
      p_show_new_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && !$past(rd_en_i) && level == LW'(1) && $past(ev_wr_acc))
          |-> (rd_data_o == $past(wr_data_i)));
    end else begin : g_reg
      logic [WIDTH-1:0] dout_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     dout_q <= '0;
        else if (ev_pop) dout_q <= head;
      end
      assign rd_data_o = dout_q;

      // R5: output only moves on an accepted read
      p_hold_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && !$past(ev_pop)) |-> $stable(rd_data_o));
    end
  endgenerate

  assign readable_o = readable;
  assign writable_o = writable;
  assign level_o    = level;

  // R2: level follows accepted pushes and pops
  p_level_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (32'(level) == 32'($past(level)) + 32'($past(ev_push))
                                  - 32'($past(ev_pop))));
  // R3: flags track the level
  p_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (readable_o == (level_o != '0)) && (writable_o == (32'(level_o) < DEPTH)));
  // R6 / R7: a replace never changes the level by itself
  p_replace_keeps_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rep_i && !rd_en_i) |=> $stable(level_o));
endmodule

// File: tb/sfifo_replace_tb.sv
`timescale 1ns/1ps
module sfifo_replace_tb;
  localparam int PERIOD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, rep = 1'b0;
  logic [7:0] din = 8'h00;

  logic [7:0] dout_a, dout_b;
  logic       rd_a, wr_a, rd_b, wr_b;
  logic [2:0] lvl_a, lvl_b;

  always #(PERIOD/2) clk = ~clk;

  // Fall-through, depth 5 (non-power-of-two)
  sfifo_replace #(.WIDTH(8), .DEPTH(5), .FWFT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .rep_i(rep), .wr_data_i(din),
    .rd_en_i(re), .rd_data_o(dout_a), .readable_o(rd_a), .writable_o(wr_a),
    .level_o(lvl_a)
  );
  // Registered read, depth 4
  sfifo_replace #(.WIDTH(8), .DEPTH(4), .FWFT(1'b0)) u_dut_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .rep_i(rep), .wr_data_i(din),
    .rd_en_i(re), .rd_data_o(dout_b), .readable_o(rd_b), .writable_o(wr_b),
    .level_o(lvl_b)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model, index 0 = fall-through depth 5, index 1 = registered depth 4
  logic [7:0] mq [2][8];
  int         mcnt [2];
  logic [7:0] mreg [2];
  int         mdep [2] = '{5, 4};

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      mcnt[k] = 0;
      mreg[k] = 8'h00;
    end
  endtask

  task automatic model_step(input int k, input logic w, input logic r, input logic p,
                            input logic [7:0] d);
    bit wok, rok;
    wok = w && (p ? (mcnt[k] > 0) : (mcnt[k] < mdep[k]));
    rok = r && (mcnt[k] > 0);
    if (rok) mreg[k] = mq[k][0];
    if (wok && p) mq[k][mcnt[k]-1] = d;
    if (rok) begin
      for (int i = 0; i < 7; i++) mq[k][i] = mq[k][i+1];
      mcnt[k] = mcnt[k] - 1;
    end
    if (wok && !p) begin
      mq[k][mcnt[k]] = d;
      mcnt[k] = mcnt[k] + 1;
    end
  endtask

  task automatic check_one(input string tag, input int k);
    logic [15:0] act, exp;
    bit          cmp_data;
    if (k == 0) begin
      cmp_data = (mcnt[0] > 0);
      act = {5'(lvl_a), rd_a, wr_a, 1'b0, cmp_data ? dout_a : 8'h00};
      exp = {5'(mcnt[0]), mcnt[0] > 0, mcnt[0] < 5, 1'b0,
             cmp_data ? mq[0][0] : 8'h00};
    end else begin
      act = {5'(lvl_b), rd_b, wr_b, 1'b0, dout_b};
      exp = {5'(mcnt[1]), mcnt[1] > 0, mcnt[1] < 4, 1'b0, mreg[1]};
    end
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dut%0d {level,readable,writable,-,data} actual=%h expected=%h",
               tag, k, act, exp);
    end
  endtask

  task automatic check_both(input string tag);
    check_one(tag, 0);
    check_one(tag, 1);
  endtask

  // Apply one cycle: drive at negedge, update model, check at the next negedge
  task automatic cycle(input logic w, input logic r, input logic p, input logic [7:0] d,
                       input string tag);
    we = w; re = r; rep = p; din = d;
    model_step(0, w, r, p, d);
    model_step(1, w, r, p, d);
    @(negedge clk);
    check_both(tag);
  endtask

  // Stimulus table {we, re, rep, din}
  localparam int NSTIM = 26;
  localparam logic [10:0] STIM [NSTIM] = '{
    {3'b100, 8'h11}, {3'b100, 8'h22}, {3'b000, 8'h00}, {3'b101, 8'h33}, // R6 overwrite
    {3'b010, 8'h00}, {3'b010, 8'h00}, {3'b010, 8'h00},                   // R8 read empty
    {3'b101, 8'h44},                                                     // R7 rep empty
    {3'b100, 8'h55}, {3'b100, 8'h66}, {3'b100, 8'h77}, {3'b100, 8'h88},
    {3'b100, 8'h99}, {3'b100, 8'hAA},                                    // R8 write full
    {3'b101, 8'hBB},                                                     // R6 rep at full
    {3'b110, 8'hCC}, {3'b110, 8'hDD},                                    // R2 same cycle
    {3'b010, 8'h00}, {3'b010, 8'h00}, {3'b010, 8'h00}, {3'b010, 8'h00},
    {3'b010, 8'h00}, {3'b010, 8'h00},
    {3'b110, 8'hEE},                                                     // R4 write to empty
    {3'b101, 8'hF0},                                                     // R4 rep at level 1
    {3'b111, 8'h0F}                                                      // R5 rep+read
  };

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    check_both("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 after release");

    for (int i = 0; i < NSTIM; i++)
      cycle(STIM[i][10], STIM[i][9], STIM[i][8], STIM[i][7:0],
            "R2/R3/R4/R5/R6/R7/R8 table");

    // Long pseudo-random run: many wrap-arounds of both pointers
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[5], lfsr[1] | (lfsr[6] & lfsr[7]),
            lfsr[2] & lfsr[3] & lfsr[4], lfsr[15:8], "R9 order across wraps");
    end

    // Fill, then reset in mid-run
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0, 8'(8'h40 + i), "R2 fill");
    we = 1'b0; re = 1'b0; rep = 1'b0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_both("R1 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 release again");

    // Replace on an empty queue, then a plain write shows only the new word
    cycle(1'b1, 1'b0, 1'b1, 8'h5A, "R7 replace when empty");
    cycle(1'b1, 1'b0, 1'b0, 8'h3C, "R4 first word falls through");
    cycle(1'b0, 1'b1, 1'b0, 8'h00, "R5 registered read");
    cycle(1'b0, 1'b0, 1'b0, 8'h00, "R5 hold after read");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule